// File: doc/BRIEF.md
# Oversampled UART Baud Tick Generator

This block turns one packed 32-bit baud configuration word into the timing strobes a UART needs. A clock divisor counter produces a sample-rate tick. A second counter groups those ticks into bit periods, and from that count it marks the last sample of each bit and the mid-bit sample. In both-edge mode the block also emits an early tick half a sample period ahead of each sample tick, so a receiver can base its sample decision on two points per sample period. This is what low oversampling ratios need.

The word is registered inside the block. Any change to it restarts both counters on the next clock, so a bit period never mixes old and new settings. The character-length and stop-bit selections in the word carry no timing meaning here. They are decoded and passed on to the shift logic.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and after reset while the word is zero, every strobe output and both decoded control outputs are low.
- R2: The divisor field sits at bits 12:0. With a non-zero divisor D and the block enabled, `sample_tick_o` is a one-cycle pulse once every D clock cycles.
- R3: With a divisor field of 0, no strobe of any kind is produced.
- R4: While `en_i` is low no strobe is produced. When `en_i` rises, the first sample tick appears in the D-th cycle, counting the cycle in which `en_i` is first high as cycle one.
- R5: The oversampling field sits at bits 28:24 and holds the ratio minus one. `bit_tick_o` pulses together with every ratio-th sample tick, which closes a bit period.
- R6: An oversampling field value below 3, which would give a ratio below 4, is treated as a ratio of 16.
- R7: `mid_tick_o` pulses together with sample tick number floor(ratio/2) of each bit period, counting from one.
- R8: Bit 17 enables both-edge mode. With it set and D at least 2, `early_tick_o` pulses ceil(D/2) cycles before every sample tick. With bit 17 clear, or with D equal to 1, it stays low.
- R9: `mid_early_o` pulses on the early tick that precedes each mid-bit sample tick, and at no other time.
- R10: `char10_o` follows bit 29 and `stop2_o` follows bit 13 of the stored word, one cycle after the word is applied.
- R11: In the cycle in which the applied word differs from the stored one, no strobe is produced. Both counters then restart, and the first sample tick appears D cycles after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Enables tick generation; low clears the counters |
| cfg_word_i | input | 32 | Packed baud configuration word |
| sample_tick_o | output | 1 | Sample-rate strobe |
| early_tick_o | output | 1 | Half-sample-period early strobe in both-edge mode |
| bit_tick_o | output | 1 | Last sample of a bit period |
| mid_tick_o | output | 1 | Mid-bit sample strobe |
| mid_early_o | output | 1 | Early strobe preceding the mid-bit sample |
| char10_o | output | 1 | Decoded 10-bit character select |
| stop2_o | output | 1 | Decoded two-stop-bit select |

## Verification
The hardest case to reach from the ports is the exact phase relation between the divisor counter and the ratio counter after a restart. A word reload or an enable edge must put both counters back at zero in the same cycle. If it does not, the mid and bit strobes slip against the sample ticks by a few cycles, and that only shows after several bit periods. The stimulus sweeps divisors of 1, 2, 3 and 5 against oversampling fields that cover the clamp, the smallest ratios, odd ratios and the largest ratio, with both-edge mode on and off. Every configuration is applied as a fresh word and tracked for two full bit periods against an arithmetic cycle model. An enable drop is inserted in the middle of a running bit period.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

   // packed word geometry
   localparam int CFG_W      = 32;
   localparam int DIV_W      = 13;
   localparam int DIV_LSB    = 0;
   localparam int OSR_W      = 5;
   localparam int OSR_LSB    = 24;
   localparam int BOTH_BIT   = 17;
   localparam int STOP2_BIT  = 13;
   localparam int CHAR10_BIT = 29;

   // ratio handling
   localparam int RATIO_W    = OSR_W + 1;
   localparam int RATIO_MIN  = 4;
   localparam int RATIO_DFLT = 16;

   typedef struct packed {
      logic [DIV_W-1:0]   div;
      logic [RATIO_W-1:0] ratio;
      logic               both;
      logic               char10;
      logic               stop2;
   } baud_cfg_t;

endpackage

// File: rtl/baud_cfg_decode.sv
module baud_cfg_decode
   import baud_tick_pkg::*;
#(
   parameter int MIN_RATIO      = RATIO_MIN,
   parameter int FALLBACK_RATIO = RATIO_DFLT
) (
   input  logic [CFG_W-1:0] word_i,
   output baud_cfg_t        cfg_o
);

   localparam int MAX_RATIO = 1 << OSR_W;

   initial begin
      assert (FALLBACK_RATIO >= MIN_RATIO && FALLBACK_RATIO <= MAX_RATIO)
         else $fatal(1, "fallback ratio outside supported range");
      assert (MIN_RATIO >= 2)
         else $fatal(1, "minimum ratio must allow a mid-bit point");
      assert (OSR_LSB + OSR_W <= CFG_W && DIV_LSB + DIV_W <= CFG_W)
         else $fatal(1, "field does not fit in configuration word");
   end

   logic [OSR_W-1:0]   osr_field;
   logic [RATIO_W-1:0] raw_ratio;
   logic               ratio_low;
   logic               unused_bits;

   assign osr_field   = word_i[OSR_LSB +: OSR_W];
   assign raw_ratio   = RATIO_W'(osr_field) + RATIO_W'(1);
   assign ratio_low   = raw_ratio < RATIO_W'(MIN_RATIO);
   assign unused_bits = ^word_i;

   always_comb begin
      cfg_o        = '0;
      cfg_o.div    = word_i[DIV_LSB +: DIV_W];
      cfg_o.ratio  = ratio_low ? RATIO_W'(FALLBACK_RATIO) : raw_ratio;
      cfg_o.both   = word_i[BOTH_BIT];
      cfg_o.char10 = word_i[CHAR10_BIT];
      cfg_o.stop2  = word_i[STOP2_BIT];
   end

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
   parameter int CNT_W   = 13,
   parameter bit HALF_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] div_i,
   input  logic             both_i,
   output logic             tick_o,
   output logic             half_o,
   output logic [CNT_W-1:0] cnt_o
);

   initial begin
      assert (CNT_W >= 2) else $fatal(1, "divisor counter too narrow");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             active;
   logic             wrap;

   assign active = run_i && (div_i != '0);
   assign wrap   = (cnt_q == div_i - CNT_W'(1));
   assign tick_o = active && wrap;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i || !active) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   generate
      if (HALF_EN) begin : g_half
         logic [CNT_W-1:0] half_pt;
         assign half_pt = (div_i >> 1) - CNT_W'(1);
         assign half_o  = active && both_i && (div_i >= CNT_W'(2)) &&
                          (cnt_q == half_pt);
      end else begin : g_no_half
         logic unused_both;
         assign unused_both = both_i;
         assign half_o      = 1'b0;
      end
   endgenerate

   // R3
   zero_div_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_i == '0) |-> (!tick_o && !half_o));

   // R8
   half_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(half_o && tick_o));

   // R2
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active |-> (cnt_q < div_i));

endmodule

// File: rtl/baud_ratio_counter.sv
module baud_ratio_counter #(
   parameter int IDX_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             half_i,
   input  logic [IDX_W-1:0] ratio_i,
   output logic             bit_o,
   output logic             mid_o,
   output logic             mid_half_o
);

   initial begin
      assert (IDX_W >= 3) else $fatal(1, "ratio counter too narrow");
   end

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] mid_pt;
   logic             last;
   logic             at_mid;

   assign last       = (idx_q == ratio_i - IDX_W'(1));
   assign mid_pt     = (ratio_i >> 1) - IDX_W'(1);
   assign at_mid     = (idx_q == mid_pt);
   assign bit_o      = tick_i && last;
   assign mid_o      = tick_i && at_mid;
   assign mid_half_o = half_i && at_mid;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (tick_i) begin
         idx_q <= last ? '0 : idx_q + IDX_W'(1);
      end
   end

   // R5
   bit_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_o |-> tick_i);

   // R7
   mid_not_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mid_o && bit_o));

   // R9
   mid_half_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mid_half_o |-> (half_i && !tick_i));

   // R5
   idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q < ratio_i);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_tick_pkg::*;
#(
   parameter bit HALF_EN        = 1'b1,
   parameter int MIN_RATIO      = RATIO_MIN,
   parameter int FALLBACK_RATIO = RATIO_DFLT
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CFG_W-1:0] cfg_word_i,
   output logic             sample_tick_o,
   output logic             early_tick_o,
   output logic             bit_tick_o,
   output logic             mid_tick_o,
   output logic             mid_early_o,
   output logic             char10_o,
   output logic             stop2_o
);

   logic [CFG_W-1:0] word_q;
   logic             word_chg;
   logic             run;
   logic             clr;
   baud_cfg_t        cfg;
   logic [DIV_W-1:0] div_cnt;

   assign word_chg = (cfg_word_i != word_q);
   assign run      = en_i && !word_chg;
   assign clr      = word_chg || !en_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         word_q <= '0;
      end else begin
         word_q <= cfg_word_i;
      end
   end

   baud_cfg_decode #(
      .MIN_RATIO      (MIN_RATIO),
      .FALLBACK_RATIO (FALLBACK_RATIO)
   ) u_decode (
      .word_i (word_q),
      .cfg_o  (cfg)
   );

   baud_div_counter #(
      .CNT_W   (DIV_W),
      .HALF_EN (HALF_EN)
   ) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .run_i  (run),
      .div_i  (cfg.div),
      .both_i (cfg.both),
      .tick_o (sample_tick_o),
      .half_o (early_tick_o),
      .cnt_o  (div_cnt)
   );

   baud_ratio_counter #(
      .IDX_W (RATIO_W)
   ) u_ratio (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .tick_i     (sample_tick_o),
      .half_i     (early_tick_o),
      .ratio_i    (cfg.ratio),
      .bit_o      (bit_tick_o),
      .mid_o      (mid_tick_o),
      .mid_half_o (mid_early_o)
   );

   assign char10_o = cfg.char10;
   assign stop2_o  = cfg.stop2;

   // R11
   reload_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_chg |-> (!sample_tick_o && !early_tick_o));

   // R11
   reload_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_chg |=> (div_cnt == '0));

   // R4
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> (!sample_tick_o && !early_tick_o && !bit_tick_o));

endmodule

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        en;
   logic [31:0] cfg;
   logic        s_tick, e_tick, b_tick, m_tick, me_tick, c10, st2;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   baud_tick_gen u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .en_i          (en),
      .cfg_word_i    (cfg),
      .sample_tick_o (s_tick),
      .early_tick_o  (e_tick),
      .bit_tick_o    (b_tick),
      .mid_tick_o    (m_tick),
      .mid_early_o   (me_tick),
      .char10_o      (c10),
      .stop2_o       (st2)
   );

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic chk_quiet(input string tag);
      chk(s_tick,  1'b0, tag, "sample");
      chk(e_tick,  1'b0, tag, "early");
      chk(b_tick,  1'b0, tag, "bit");
      chk(m_tick,  1'b0, tag, "mid");
      chk(me_tick, 1'b0, tag, "mid_early");
   endtask

   function automatic int exp_ratio(input int field);
      return (field < 3) ? 16 : field + 1;
   endfunction

   // apply a word; the cycle it differs from the stored word must be quiet (R11)
   task automatic apply_word(input int div, input int field, input int both, input logic [31:0] extra);
      @(posedge clk);
      #1 cfg = (32'(field) << 24) | (32'(both) << 17) | 32'(div) | extra;
      @(negedge clk);
      chk_quiet("R11");
   endtask

   // compare outputs against the cycle model for ncyc cycles; cycle 0 is the next negedge
   task automatic track(input int div, input int ratio, input int both, input int ncyc, input string ctx);
      for (int n = 0; n < ncyc; n++) begin
         @(negedge clk);
         begin
            logic hit, early;
            int s, pos, up;
            hit   = ((n + 1) % div) == 0;
            s     = (n + 1) / div;
            pos   = (s > 0) ? ((s - 1) % ratio) + 1 : 0;
            up    = ((n / div) % ratio) + 1;
            early = (both != 0) && (div >= 2) && ((n % div) == (div / 2) - 1);
            chk(s_tick, hit, "R2", ctx);
            chk(b_tick, hit && (pos == ratio), (ratio == 16) ? "R6" : "R5", ctx);
            chk(m_tick, hit && (pos == ratio / 2), "R7", ctx);
            chk(e_tick, early, "R8", ctx);
            chk(me_tick, early && (up == ratio / 2), "R9", ctx);
         end
      end
   endtask

   initial begin
      int divs [4]   = '{1, 2, 3, 5};
      int fields [7] = '{0, 2, 3, 4, 6, 15, 31};
      rst_n = 1'b0;
      en    = 1'b0;
      cfg   = '0;
      // R1: quiet in reset
      repeat (3) begin
         @(negedge clk);
         chk_quiet("R1");
         chk(c10, 1'b0, "R1", "char10");
         chk(st2, 1'b0, "R1", "stop2");
      end
      @(posedge clk);
      #1 rst_n = 1'b1;
      en = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk_quiet("R1");
         chk(c10, 1'b0, "R1", "char10");
      end

      // R11 reload, sweep of divisor, ratio and mode
      foreach (divs[i]) begin
         foreach (fields[j]) begin
            for (int b = 0; b < 2; b++) begin
               int r;
               r = exp_ratio(fields[j]);
               apply_word(divs[i], fields[j], b, 32'h0);
               track(divs[i], r, b, 2 * divs[i] * r + 3, "R11 reload");
            end
         end
      end

      // R10: decoded control bits
      apply_word(2, 15, 0, 32'h2000_0000);
      @(negedge clk);
      chk(c10, 1'b1, "R10", "char10 set");
      chk(st2, 1'b0, "R10", "stop2 clear");
      apply_word(2, 15, 0, 32'h0000_2000);
      @(negedge clk);
      chk(c10, 1'b0, "R10", "char10 clear");
      chk(st2, 1'b1, "R10", "stop2 set");

      // R3: divisor zero gives nothing
      apply_word(0, 15, 1, 32'h0);
      repeat (60) begin
         @(negedge clk);
         chk_quiet("R3");
      end

      // R4: enable drop mid-bit, then restart timing
      apply_word(3, 3, 1, 32'h0);
      track(3, 4, 1, 17, "R4 run");
      @(posedge clk);
      #1 en = 1'b0;
      repeat (10) begin
         @(negedge clk);
         chk_quiet("R4");
      end
      @(posedge clk);
      #1 en = 1'b1;
      track(3, 4, 1, 2 * 3 * 4 + 3, "R4 restart");

      // odd divisor in both-edge mode with odd ratio, after enable restart
      apply_word(5, 4, 1, 32'h0);
      track(5, 5, 1, 2 * 5 * 5 + 3, "R8 odd");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule